// File: doc/BRIEF.md
# PHY Initialization Script Sequencer

This block brings an external PHY to a known configuration after power-up. It follows a script held in a word-addressed memory, which it reads through a simple synchronous-read port. On a start pulse it first soft-resets the PHY and polls the reset bit until it clears. It then reads a pointer word from a fixed memory address. The pointer leads to a list of (module ID, script address) pairs, and the block scans that list for the requested module type. When an entry matches, it runs the script found at that entry's address.

Every script word has a 4-bit kind in its top bits and a 12-bit value below it. A wait word stalls for a number of milliseconds. A burst word gives a count N; the word after it is a PHY register address, and the next N words are written to consecutive registers starting at that address. Marker words either skip (start-of-list) or finish (end-of-list). PHY accesses use a valid/ready request port and a separate read-response strobe. The run ends with a held `done` flag or a held `error` flag plus a code.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `phy_valid` and `mem_rd_en` are low and `err_code` is 0.
- R2: On start, the block first writes 0x8000 (bit 15 set) to PHY register 0x0000. It then reads that register until a response shows bit 15 clear. If POLL_LIMIT (default 100) reads all show the bit set, the run ends with error code 3 and no further PHY writes.
- R3: The pointer word is read from memory address PTR_ADDR (default 0). A value of 0x0000 or 0xFFFF ends the run with error code 1.
- R4: The ID list starts at the pointed address and holds pairs: a module ID word, then a script-address word. The first ID equal to `module_type` selects its script. An ID word of 0xFFFF ends the list and gives error code 2.
- R5: A selected script address of 0x0000 or 0xFFFF gives error code 2 and no script writes.
- R6: In a script word, bits [15:12] are the kind and bits [11:0] the value. Kind 1 is a burst of N = value. The next word is the PHY address A, and the N words after it are written in order to A, A+1, ... A+N-1. N = 0 writes nothing.
- R7: Kind 0 waits at least value × CLK_KHZ clock cycles, and issues no PHY request during the wait.
- R8: Kind 0xF with value 0xFFF ends the run with `done`. Kind 0xF with value 0x001 is skipped. Any other kind 0xF value, and any kind from 2 to 0xE, ends the run with error code 4 and no further writes.
- R9: A PHY request keeps `phy_valid`, `phy_write`, `phy_addr` and `phy_wdata` unchanged until `phy_ready` accepts it.
- R10: `done` and `error` are never high together. Each stays high until the next accepted start. A start pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| module_type | input | 16 | Module ID searched for in the list |
| mem_rd_en | output | 1 | Script memory read strobe |
| mem_addr | output | MEM_AW (8) | Script memory word address |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| phy_valid | output | 1 | PHY request valid |
| phy_ready | input | 1 | PHY request accepted |
| phy_write | output | 1 | 1 = register write, 0 = register read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_rdata_valid | input | 1 | PHY read response strobe |
| phy_rdata | input | 16 | PHY read response data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| error | output | 1 | Last run failed |
| err_code | output | 3 | 1 no script, 2 unsupported, 3 reset stuck, 4 bad word |

## Verification
The bench sweeps burst lengths from zero to six, with the PHY accepting requests at once and with stalls. A block that miscounted the burst, or mishandled a zero count, would write the wrong number of registers or take the address word as data. It builds every invalid pointer and script-address value, a missing ID and both kinds of bad script word, and checks the exact error code and that no writes follow. It also holds the reset bit set for longer than the poll limit to confirm exactly POLL_LIMIT reads before the failure. Finally, it measures the gap around a wait word to catch a prescaler that runs short.

// File: rtl/phyinit_pkg.sv
// Shared types and constants for the PHY initialization sequencer.
// Assumes 16-bit script words: 4-bit kind on top, 12-bit value below.
package phyinit_pkg;

    typedef enum logic [2:0] {
        K_DELAY,
        K_DATA,
        K_SKIP,
        K_END,
        K_BAD
    } word_kind_t;

    typedef enum logic [2:0] {
        E_NONE        = 3'd0,
        E_NO_SCRIPT   = 3'd1,
        E_UNSUPPORTED = 3'd2,
        E_RESET_STUCK = 3'd3,
        E_BAD_WORD    = 3'd4
    } err_t;

    localparam logic [3:0] KIND_DELAY = 4'h0;
    localparam logic [3:0] KIND_DATA  = 4'h1;
    localparam logic [3:0] KIND_CTRL  = 4'hF;

endpackage

// File: rtl/phyinit_word_dec.sv
// Splits one script word into kind and value and classifies it.
// Assumes the kind sits in the top four bits of the word.
module phyinit_word_dec
    import phyinit_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int VAL_W  = WORD_W - 4
) (
    input  logic [WORD_W-1:0] word,
    output word_kind_t        kind,
    output logic [VAL_W-1:0]  value
);
    localparam logic [VAL_W-1:0] VAL_EOL = '1;
    localparam logic [VAL_W-1:0] VAL_SOL = VAL_W'(1);

    logic [3:0] kind_f;

    assign kind_f = word[WORD_W-1 -: 4];
    assign value  = word[VAL_W-1:0];

    // Classify the word by its kind and, for markers, its value.
    always_comb begin
        unique case (kind_f)
            KIND_DELAY: kind = K_DELAY;
            KIND_DATA:  kind = K_DATA;
            KIND_CTRL: begin
                if (value == VAL_EOL)      kind = K_END;
                else if (value == VAL_SOL) kind = K_SKIP;
                else                       kind = K_BAD;
            end
            default:    kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/phyinit_ms_timer.sv
// Millisecond down-counter with a prescaler of CLK_KHZ cycles per tick.
// A load of N makes expired low for N*CLK_KHZ cycles; N=0 expires at once.
module phyinit_ms_timer #(
    parameter int CLK_KHZ = 250000,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_ms,
    output logic             expired
);
    localparam int PRE_W   = $clog2(CLK_KHZ + 1);
    localparam int PRE_MAX = (CLK_KHZ > 1) ? CLK_KHZ - 1 : 0;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] rem_q;

    // Count prescaler cycles and decrement the remaining milliseconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            rem_q <= load_ms;
        end else if (rem_q != '0) begin
            if (pre_q == PRE_W'(PRE_MAX)) begin
                pre_q <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (rem_q == '0) && !load;

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem_q != '0) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1)); // R7
endmodule

// File: rtl/phy_init_seq.sv
// Resets a PHY, finds a module's script through an ID list in memory and
// replays it as PHY register writes. Assumes memory read data arrives one
// cycle after mem_rd_en and PHY read data arrives on phy_rdata_valid.
module phy_init_seq
    import phyinit_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          MEM_AW     = 8,
    parameter int          CLK_KHZ    = 250000,
    parameter int          POLL_LIMIT = 100,
    parameter int          PTR_ADDR   = 0,
    parameter int          RST_REG    = 0,
    parameter int          RST_BIT    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] module_type,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              phy_valid,
    input  logic              phy_ready,
    output logic              phy_write,
    output logic [WORD_W-1:0] phy_addr,
    output logic [WORD_W-1:0] phy_wdata,
    input  logic              phy_rdata_valid,
    input  logic [WORD_W-1:0] phy_rdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [2:0]        err_code
);
    localparam int VAL_W  = WORD_W - 4;
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [WORD_W-1:0] W_ZERO = '0;
    localparam logic [WORD_W-1:0] W_ONES = '1;

    typedef enum logic [4:0] {
        S_IDLE, S_RST_WR, S_POLL_RD, S_POLL_WAIT,
        S_PTR_REQ, S_PTR_CHK, S_ID_REQ, S_ID_CHK, S_OFF_REQ, S_OFF_CHK,
        S_W_REQ, S_W_DEC, S_DLY, S_A_REQ, S_A_CAP, S_D_REQ, S_D_CAP, S_D_WR
    } state_t;

    state_t            state_q;
    logic [MEM_AW-1:0] pc_q;
    logic [VAL_W-1:0]  burst_q;
    logic [POLL_W-1:0] poll_q;
    logic              done_q, err_q, valid_q, write_q;
    logic [WORD_W-1:0] addr_q, wdata_q;
    err_t              code_q;
    word_kind_t        kind;
    logic [VAL_W-1:0]  value;
    logic              tmr_load, tmr_expired;
    logic              word_bad;

    phyinit_word_dec #(.WORD_W(WORD_W), .VAL_W(VAL_W)) u_dec (
        .word (mem_rdata),
        .kind (kind),
        .value(value)
    );

    phyinit_ms_timer #(.CLK_KHZ(CLK_KHZ), .CNT_W(VAL_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .load_ms(value),
        .expired(tmr_expired)
    );

    // Memory strobe in every request state; pointer read uses the fixed address.
    always_comb begin
        mem_rd_en = (state_q == S_PTR_REQ) || (state_q == S_ID_REQ) ||
                    (state_q == S_OFF_REQ) || (state_q == S_W_REQ)  ||
                    (state_q == S_A_REQ)   || (state_q == S_D_REQ);
        mem_addr  = (state_q == S_PTR_REQ) ? MEM_AW'(PTR_ADDR) : pc_q;
    end

    assign word_bad = (mem_rdata == W_ZERO) || (mem_rdata == W_ONES);
    assign tmr_load = (state_q == S_W_DEC) && (kind == K_DELAY);

    // Main sequencing: reset and poll, list lookup, then script replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            burst_q <= '0;
            poll_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= E_NONE;
            valid_q <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    code_q  <= E_NONE;
                    poll_q  <= '0;
                    valid_q <= 1'b1;
                    write_q <= 1'b1;
                    addr_q  <= WORD_W'(RST_REG);
                    wdata_q <= W_ZERO | (WORD_W'(1) << RST_BIT);
                    state_q <= S_RST_WR;
                end
                S_RST_WR: if (phy_ready) begin
                    write_q <= 1'b0;
                    state_q <= S_POLL_RD;
                end
                S_POLL_RD: if (phy_ready) begin
                    valid_q <= 1'b0;
                    poll_q  <= poll_q + 1'b1;
                    state_q <= S_POLL_WAIT;
                end
                S_POLL_WAIT: if (phy_rdata_valid) begin
                    if (!phy_rdata[RST_BIT]) begin
                        state_q <= S_PTR_REQ;
                    end else if (poll_q == POLL_W'(POLL_LIMIT)) begin
                        err_q   <= 1'b1;
                        code_q  <= E_RESET_STUCK;
                        state_q <= S_IDLE;
                    end else begin
                        valid_q <= 1'b1;
                        state_q <= S_POLL_RD;
                    end
                end
                S_PTR_REQ: state_q <= S_PTR_CHK;
                S_PTR_CHK: begin
                    if (word_bad) begin
                        err_q   <= 1'b1;
                        code_q  <= E_NO_SCRIPT;
                        state_q <= S_IDLE;
                    end else begin
                        pc_q    <= mem_rdata[MEM_AW-1:0];
                        state_q <= S_ID_REQ;
                    end
                end
                S_ID_REQ: state_q <= S_ID_CHK;
                S_ID_CHK: begin
                    if (mem_rdata == W_ONES) begin
                        err_q   <= 1'b1;
                        code_q  <= E_UNSUPPORTED;
                        state_q <= S_IDLE;
                    end else if (mem_rdata == module_type) begin
                        pc_q    <= pc_q + 1'b1;
                        state_q <= S_OFF_REQ;
                    end else begin
                        pc_q    <= pc_q + MEM_AW'(2);
                        state_q <= S_ID_REQ;
                    end
                end
                S_OFF_REQ: state_q <= S_OFF_CHK;
                S_OFF_CHK: begin
                    if (word_bad) begin
                        err_q   <= 1'b1;
                        code_q  <= E_UNSUPPORTED;
                        state_q <= S_IDLE;
                    end else begin
                        pc_q    <= mem_rdata[MEM_AW-1:0];
                        state_q <= S_W_REQ;
                    end
                end
                S_W_REQ: state_q <= S_W_DEC;
                S_W_DEC: begin
                    pc_q <= pc_q + 1'b1;
                    unique case (kind)
                        K_DELAY: state_q <= S_DLY;
                        K_DATA: begin
                            burst_q <= value;
                            state_q <= S_A_REQ;
                        end
                        K_SKIP:  state_q <= S_W_REQ;
                        K_END: begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                        default: begin
                            err_q   <= 1'b1;
                            code_q  <= E_BAD_WORD;
                            state_q <= S_IDLE;
                        end
                    endcase
                end
                S_DLY: if (tmr_expired) state_q <= S_W_REQ;
                S_A_REQ: state_q <= S_A_CAP;
                S_A_CAP: begin
                    addr_q  <= mem_rdata;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= (burst_q == '0) ? S_W_REQ : S_D_REQ;
                end
                S_D_REQ: state_q <= S_D_CAP;
                S_D_CAP: begin
                    wdata_q <= mem_rdata;
                    valid_q <= 1'b1;
                    write_q <= 1'b1;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= S_D_WR;
                end
                S_D_WR: if (phy_ready) begin
                    valid_q <= 1'b0;
                    addr_q  <= addr_q + 1'b1;
                    burst_q <= burst_q - 1'b1;
                    state_q <= (burst_q == VAL_W'(1)) ? S_W_REQ : S_D_REQ;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign phy_valid = valid_q;
    assign phy_write = write_q;
    assign phy_addr  = addr_q;
    assign phy_wdata = wdata_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign error     = err_q;
    assign err_code  = code_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_valid && !phy_ready) |=> (phy_valid && $stable(phy_addr) &&
                                       $stable(phy_wdata) && $stable(phy_write))); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !phy_valid)); // R10
    AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != 3'd0)); // R3
    AST_POLL_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(error) && err_code == 3'd3) |-> (poll_q == POLL_W'(POLL_LIMIT))); // R2
    AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_expired |-> !phy_valid); // R7
endmodule

// File: tb/test_phy_init_seq.sv
module test_phy_init_seq;
    localparam int K = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] module_type = '0;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        phy_valid, phy_write;
    logic        phy_ready = 1'b1;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_rdata_valid = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        busy, done, error;
    logic [2:0]  err_code;

    logic [15:0] mem [0:255];
    logic [15:0] wr_addr [0:63];
    logic [15:0] wr_data [0:63];
    int          wr_cyc  [0:63];
    int          wr_n = 0, rd_n = 0, cyc = 0;
    int          busy_polls = 0;
    logic        stall = 1'b0;
    logic        log_clr = 1'b0;
    int          checks = 0, fails = 0;

    always #2 clk = ~clk;

    phy_init_seq #(.CLK_KHZ(K)) i_phy_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .module_type(module_type),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .phy_valid(phy_valid), .phy_ready(phy_ready), .phy_write(phy_write),
        .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_rdata_valid(phy_rdata_valid), .phy_rdata(phy_rdata),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    // Synchronous-read memory model and PHY model with logging.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (log_clr) begin
            wr_n <= 0;
            rd_n <= 0;
            phy_rdata_valid <= 1'b0;
        end else begin
            phy_rdata_valid <= phy_valid && phy_ready && !phy_write;
            phy_rdata <= (rd_n < busy_polls) ? 16'h8000 : 16'h0000;
            if (phy_valid && phy_ready) begin
                if (phy_write) begin
                    if (wr_n < 64) begin
                        wr_addr[wr_n] <= phy_addr;
                        wr_data[wr_n] <= phy_wdata;
                        wr_cyc[wr_n]  <= cyc;
                    end
                    wr_n <= wr_n + 1;
                end else begin
                    rd_n <= rd_n + 1;
                end
            end
        end
    end

    always @(negedge clk) phy_ready = stall ? ((cyc % 3) != 1) : 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mem_clear();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic run(input logic [15:0] mtype);
        module_type = mtype;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t < 20000 && !(done || error); t++) @(negedge clk);
    endtask

    // Common list: pointer at 0 -> 0x10; id 7 -> 0x90, id 0xA -> 0x40.
    task automatic std_list();
        mem_clear();
        mem[0] = 16'h0010;
        mem[16'h10] = 16'h0007; mem[16'h11] = 16'h0090;
        mem[16'h12] = 16'h000A; mem[16'h13] = 16'h0040;
        mem[16'h14] = 16'hFFFF;
        mem[16'h90] = 16'hFFFF;
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 error", error, 0);
        chk("R1 phy_valid", phy_valid, 0);
        chk("R1 mem_rd_en", mem_rd_en, 0);
        chk("R1 err_code", err_code, 0);
        rst_n = 1'b1;

        // Normal script with skip marker, bursts, zero burst and a wait.
        std_list();
        begin
            logic [15:0] s [0:12];
            s = '{16'hF001, 16'h1003, 16'h0100, 16'h1111, 16'h2222, 16'h3333,
                  16'h0005, 16'h1001, 16'h0200, 16'hBEEF, 16'h1000, 16'h0300, 16'hFFFF};
            for (int i = 0; i < 13; i++) mem[16'h40 + i] = s[i];
        end
        busy_polls = 2;
        module_type = 16'h000A;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;                      // R10: start while busy is ignored
        @(negedge clk) start = 1'b0;
        for (int t = 0; t < 20000 && !(done || error); t++) @(negedge clk);
        chk("R8 done", done, 1);
        chk("R10 no error", error, 0);
        chk("R2 reset write addr", wr_addr[0], 16'h0000);
        chk("R2 reset write data", wr_data[0], 16'h8000);
        chk("R2 poll reads", rd_n, 3);
        chk("R6 write count", wr_n, 5);
        for (int i = 0; i < 3; i++) begin
            chk("R6 burst addr", wr_addr[1 + i], 16'h0100 + 16'(i));
            chk("R6 burst data", wr_data[1 + i], 16'h1111 * 16'(i + 1));
        end
        chk("R6 second addr", wr_addr[4], 16'h0200);
        chk("R6 second data", wr_data[4], 16'hBEEF);
        gap = wr_cyc[4] - wr_cyc[3];
        chk("R7 wait long enough", 32'(gap >= 5 * K), 1);
        chk("R7 wait not too long", 32'(gap <= 5 * K + 16), 1);
        repeat (10) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 idle", busy, 0);

        // Sweep burst length 0..6 with and without PHY stalls.
        mem_clear();
        mem[0] = 16'h0010;
        for (int k = 0; k < 7; k++) begin
            int b;
            b = 16'h40 + 12 * k;
            mem[16'h10 + 2 * k] = 16'(k);
            mem[16'h11 + 2 * k] = 16'(b);
            mem[b] = 16'h1000 | 16'(k);
            mem[b + 1] = 16'h0010 + 16'(k * 256);
            for (int j = 0; j < k; j++) mem[b + 2 + j] = 16'hA000 + 16'(k * 16 + j);
            mem[b + 2 + k] = 16'hFFFF;
        end
        mem[16'h1E] = 16'hFFFF;
        busy_polls = 0;
        for (int st = 0; st < 2; st++) begin
            stall = st[0];
            for (int k = 0; k < 7; k++) begin
                run(16'(k));
                chk("R6 sweep done", done, 1);
                chk("R6 sweep count", wr_n, k + 1);
                for (int j = 0; j < k; j++) begin
                    chk("R6 sweep addr", wr_addr[1 + j], 16'h0010 + 16'(k * 256 + j));
                    chk("R6 sweep data", wr_data[1 + j], 16'hA000 + 16'(k * 16 + j));
                end
            end
        end
        stall = 1'b0;

        // Pointer invalid.
        std_list(); mem[0] = 16'h0000; run(16'h000A);
        chk("R3 ptr zero code", err_code, 1);
        chk("R3 ptr zero flag", error, 1);
        std_list(); mem[0] = 16'hFFFF; run(16'h000A);
        chk("R3 ptr ones code", err_code, 1);
        chk("R3 ptr ones writes", wr_n, 1);

        // ID absent from list.
        std_list(); run(16'h0055);
        chk("R4 missing id code", err_code, 2);
        chk("R4 missing id done", done, 0);

        // Script address invalid.
        std_list(); mem[16'h13] = 16'h0000; run(16'h000A);
        chk("R5 off zero code", err_code, 2);
        chk("R5 off zero writes", wr_n, 1);
        std_list(); mem[16'h13] = 16'hFFFF; run(16'h000A);
        chk("R5 off ones code", err_code, 2);

        // Bad marker value stops writes after it.
        std_list();
        begin
            logic [15:0] s [0:8];
            s = '{16'hF001, 16'h1001, 16'h0500, 16'h1234, 16'hF005,
                  16'h1001, 16'h0600, 16'h9999, 16'hFFFF};
            for (int i = 0; i < 9; i++) mem[16'h40 + i] = s[i];
        end
        run(16'h000A);
        chk("R8 bad marker code", err_code, 4);
        chk("R8 bad marker writes", wr_n, 2);
        chk("R8 bad marker data", wr_data[1], 16'h1234);
        chk("R10 excl", done, 0);

        // Unknown kinds 2..E.
        for (int ty = 2; ty < 15; ty++) begin
            std_list(); mem[16'h40] = 16'(ty << 12); run(16'h000A);
            chk("R8 unknown kind code", err_code, 4);
            chk("R8 unknown kind writes", wr_n, 1);
        end

        // Reset bit never clears.
        std_list(); busy_polls = 1000; run(16'h000A);
        chk("R2 stuck code", err_code, 3);
        chk("R2 stuck reads", rd_n, 100);
        chk("R2 stuck writes", wr_n, 1);
        busy_polls = 0;

        // Recovery after an error.
        std_list(); mem[16'h40] = 16'hFFFF; run(16'h000A);
        chk("R10 recover done", done, 1);
        chk("R10 recover error", error, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc == 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule